// File: doc/BRIEF.md
# Power-On Reset Sequencer

This block produces the chip-level reset outputs and a global output enable from two inputs. One is an asynchronous power-good level. The other is an active-low system reset that comes from the board. While power-good is low, the core clock cannot be trusted. For that reason the block clears every register and forces its reset outputs active with no help from the clock. It also pulls the output enable low so that the pads that carry data stay undriven.

Once power is good, the processor reset stays active until the synchronized system reset input is first seen inactive. That first release sets the phase of a free-running modulo-8 slot counter, and it emits a one-cycle status pulse. From then on, the block looks at the system reset input in only one slot out of eight. At a 200 MHz core clock this gives an effective 25 MHz sample rate. Because of this, every component that shares the same first release reacts to later resets on the same core edge.

Top module: `rstseq_ctrl`

## Requirements
- R1: While `pwr_ok` is 0, `cpu_rst_n` and `lpc_rst_n` are 0 immediately, with no clock edge needed.
- R2: `out_en` equals `pwr_ok` at all times, with no clock involved.
- R3: A low pulse on `pwr_ok` clears all state. After `pwr_ok` returns to 1, the processor reset stays asserted until a new first release, even if `sys_rst_n` was held at 1 the whole time.
- R4: After `pwr_ok` rises, `cpu_rst_n` stays 0 for as long as `sys_rst_n` stays 0.
- R5: The first release happens on the third rising `clk_core` edge after `sys_rst_n` goes to 1 (two synchronizer stages plus one decision register). `cpu_rst_n` is 1 from that edge onward.
- R6: `first_rel_pulse` is 1 for exactly the one cycle after the first-release edge. It does not fire again until `pwr_ok` has gone low and come back.
- R7: After the first release, `cpu_rst_n` changes only on qualifying edges. These are the edges that lie a multiple of 8 edges after the first-release edge; the release edge counts as slot 0.
- R8: On a qualifying edge, the processor reset becomes asserted (`cpu_rst_n` = 0) when `sys_rst_n` was 0 at the edge two edges earlier, and it becomes released otherwise.
- R9: A low pulse on `sys_rst_n` that is not present at the edge two before any qualifying edge has no effect on `cpu_rst_n`.
- R10: With the default configuration, `lpc_rst_n` is always equal to `cpu_rst_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_core | input | 1 | Core clock; all synchronous logic uses its rising edge |
| pwr_ok | input | 1 | Asynchronous power-good level; 0 clears all state |
| sys_rst_n | input | 1 | Active-low system reset request, asynchronous to `clk_core` |
| cpu_rst_n | output | 1 | Active-low processor reset |
| lpc_rst_n | output | 1 | Active-low reset for the low-pin-count bus side |
| out_en | output | 1 | Global enable for the block's data outputs; 0 while power is bad |
| first_rel_pulse | output | 1 | One-cycle pulse marking the first system-reset release |

## Verification
Several properties are checked on every cycle while power is good. The processor reset holds before the first release. It changes only when the slot counter signals a qualifying slot, and there it follows the synchronized input. The slot counter wraps correctly and stays cleared until it is started. The status pulse lasts one cycle and coincides with a released processor reset. Some behaviour can only be shown by the bench scenarios: the asynchronous reaction to power-good going low between clock edges, the exact three-edge release latency, and the absolute slot phase measured from the release edge. The same holds for glitches on the system reset input that fall between sampling slots and so have no effect.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

   typedef enum logic {
      SEQ_WAIT = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_e;

   function automatic int unsigned slot_count(input int unsigned width);
      return 32'd1 << width;
   endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic clr_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("rstseq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_head
         always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= d;
         end
      end else begin : g_tail
         always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/rstseq_phase.sv
module rstseq_phase #(
   parameter int unsigned PHASE_W   = 3,
   parameter int unsigned QUAL_SLOT = 0
) (
   input  logic               clk,
   input  logic               clr_n,
   input  logic               start,
   input  logic               run,
   output logic               qual,
   output logic [PHASE_W-1:0] phase
);

   localparam int unsigned NSLOTS = rstseq_pkg::slot_count(PHASE_W);

   if (PHASE_W < 1 || PHASE_W > 8) begin : g_bad_width
      $error("rstseq_phase: PHASE_W must be in 1..8");
   end
   if (QUAL_SLOT >= NSLOTS) begin : g_bad_slot
      $error("rstseq_phase: QUAL_SLOT out of range");
   end

   localparam logic [PHASE_W-1:0] SLOT_ONE  = PHASE_W'(1);
   localparam logic [PHASE_W-1:0] SLOT_QUAL = PHASE_W'(QUAL_SLOT);

   logic [PHASE_W-1:0] phase_q;

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n)     phase_q <= '0;
      else if (start) phase_q <= SLOT_ONE;
      else if (run)   phase_q <= phase_q + SLOT_ONE;
   end

   assign qual  = run && (phase_q == SLOT_QUAL);
   assign phase = phase_q;

   assert_wrap_R7: assert property (@(posedge clk) disable iff (!clr_n)
      (run && !start && phase_q == '1) |=> (phase_q == '0));

   assert_idle_clear_R3: assert property (@(posedge clk) disable iff (!clr_n)
      (!run && !start) |=> (phase_q == '0));

endmodule

// File: rtl/rstseq_core.sv
module rstseq_core (
   input  logic clk,
   input  logic clr_n,
   input  logic sync_in,
   input  logic qual,
   output logic cpu_rst,
   output logic first_pulse,
   output logic start,
   output logic run
);

   import rstseq_pkg::*;

   seq_state_e state_q;
   logic       cpu_rst_q;
   logic       pulse_q;
   logic       first_ev;

   assign first_ev = (state_q == SEQ_WAIT) && sync_in;

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) begin
         state_q   <= SEQ_WAIT;
         cpu_rst_q <= 1'b1;
         pulse_q   <= 1'b0;
      end else begin
         pulse_q <= first_ev;
         if (first_ev) begin
            state_q   <= SEQ_RUN;
            cpu_rst_q <= 1'b0;
         end else if (state_q == SEQ_RUN && qual) begin
            cpu_rst_q <= !sync_in;
         end
      end
   end

   assign cpu_rst     = cpu_rst_q;
   assign first_pulse = pulse_q;
   assign start       = first_ev;
   assign run         = (state_q == SEQ_RUN);

   assert_hold_until_first_R4: assert property (@(posedge clk) disable iff (!clr_n)
      (state_q == SEQ_WAIT && !sync_in) |=> cpu_rst_q);

   assert_only_on_slot_R7: assert property (@(posedge clk) disable iff (!clr_n)
      (state_q == SEQ_RUN && !qual) |=> $stable(cpu_rst_q));

   assert_slot_tracks_R8: assert property (@(posedge clk) disable iff (!clr_n)
      (state_q == SEQ_RUN && qual) |=> (cpu_rst_q == !$past(sync_in)));

   assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!clr_n)
      pulse_q |=> !pulse_q);

endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned PHASE_W     = 3,
   parameter int unsigned QUAL_SLOT   = 0,
   parameter bit          LPC_FOLLOW  = 1'b1
) (
   input  logic clk_core,
   input  logic pwr_ok,
   input  logic sys_rst_n,
   output logic cpu_rst_n,
   output logic lpc_rst_n,
   output logic out_en,
   output logic first_rel_pulse
);

   logic sync_rel;
   logic qual;
   logic cpu_rst;
   logic pulse;
   logic start;
   logic run;
   logic [PHASE_W-1:0] phase;

   rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk_core),
      .clr_n (pwr_ok),
      .d     (sys_rst_n),
      .q     (sync_rel)
   );

   rstseq_phase #(.PHASE_W(PHASE_W), .QUAL_SLOT(QUAL_SLOT)) u_phase (
      .clk   (clk_core),
      .clr_n (pwr_ok),
      .start (start),
      .run   (run),
      .qual  (qual),
      .phase (phase)
   );

   rstseq_core u_core (
      .clk         (clk_core),
      .clr_n       (pwr_ok),
      .sync_in     (sync_rel),
      .qual        (qual),
      .cpu_rst     (cpu_rst),
      .first_pulse (pulse),
      .start       (start),
      .run         (run)
   );

   assign cpu_rst_n       = pwr_ok & ~cpu_rst;
   assign out_en          = pwr_ok;
   assign first_rel_pulse = pulse;

   if (LPC_FOLLOW) begin : g_lpc_follow
      assign lpc_rst_n = cpu_rst_n;
   end else begin : g_lpc_once
      assign lpc_rst_n = pwr_ok & run;
   end

   logic unused_phase;
   assign unused_phase = ^phase;

   assert_pulse_release_R5: assert property (@(posedge clk_core) disable iff (!pwr_ok)
      first_rel_pulse |-> cpu_rst_n);

endmodule

// File: tb/rstseq_ctrl_tb.sv
module rstseq_ctrl_tb;

   logic clk_core = 1'b0;
   logic pwr_ok   = 1'b0;
   logic sys_rst_n = 1'b0;
   logic cpu_rst_n, lpc_rst_n, out_en, first_rel_pulse;

   always #4 clk_core = ~clk_core;

   rstseq_ctrl u_dut (
      .clk_core        (clk_core),
      .pwr_ok          (pwr_ok),
      .sys_rst_n       (sys_rst_n),
      .cpu_rst_n       (cpu_rst_n),
      .lpc_rst_n       (lpc_rst_n),
      .out_en          (out_en),
      .first_rel_pulse (first_rel_pulse)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   bit hist [0:16383];
   int ec = 0;
   int base = 0;
   bit cur_in = 1'b0;
   bit m_armed = 1'b0;
   bit m_rst = 1'b1;
   bit m_pulse = 1'b0;
   int m_rel = 0;
   bit prev_cpu = 1'b0;
   int pulse_seen = 0;

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
      end
   endtask

   function automatic bit s2_at(input int k);
      if (k - 2 >= base + 1) return hist[k-2];
      return 1'b0;
   endfunction

   task automatic cyc();
      bit s2;
      hist[ec+1] = cur_in;
      @(posedge clk_core);
      ec++;
      m_pulse = 1'b0;
      if (pwr_ok) begin
         s2 = s2_at(ec);
         if (!m_armed) begin
            if (s2) begin
               m_armed = 1'b1; m_rel = ec; m_rst = 1'b0; m_pulse = 1'b1;
            end
         end else if (((ec - m_rel) % 8) == 0) begin
            m_rst = !s2;
         end
      end
      @(negedge clk_core);
      check("R8", cpu_rst_n, pwr_ok & !m_rst);
      check("R10", lpc_rst_n, cpu_rst_n);
      check("R2", out_en, pwr_ok);
      check("R6", first_rel_pulse, m_pulse);
      if (first_rel_pulse) pulse_seen++;
      if (m_armed && ec != m_rel && cpu_rst_n !== prev_cpu)
         check("R7", (((ec - m_rel) % 8) == 0), 1'b1);
      prev_cpu = cpu_rst_n;
   endtask

   task automatic drive(input bit v);
      sys_rst_n = v;
      cur_in = v;
   endtask

   task automatic power_cycle(input bit in_during);
      pwr_ok = 1'b0;
      #1;
      check("R1", cpu_rst_n, 1'b0);
      check("R1", lpc_rst_n, 1'b0);
      check("R2", out_en, 1'b0);
      m_armed = 1'b0; m_rst = 1'b1; prev_cpu = 1'b0;
      drive(in_during);
      for (int i = 0; i < 3; i++) cyc();
      #1;
      pwr_ok = 1'b1;
      base = ec;
      #1;
      check("R2", out_en, 1'b1);
      check("R3", cpu_rst_n, 1'b0);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int lat;
      #1;
      check("R1", cpu_rst_n, 1'b0);
      check("R1", lpc_rst_n, 1'b0);
      check("R2", out_en, 1'b0);
      check("R6", first_rel_pulse, 1'b0);
      for (int i = 0; i < 3; i++) cyc();

      // R4: power good, system reset still active
      pwr_ok = 1'b1;
      base = ec;
      for (int i = 0; i < 6; i++) begin
         cyc();
         check("R4", cpu_rst_n, 1'b0);
      end

      // R5: release latency of three edges
      drive(1'b1);
      lat = 0;
      for (int i = 0; i < 6; i++) begin
         cyc();
         if (cpu_rst_n && lat == 0) lat = i + 1;
      end
      check("R5", (lat == 3), 1'b1);
      for (int i = 0; i < 20; i++) cyc();
      check("R6", (pulse_seen == 1), 1'b1);

      // R9: glitch between sampling points
      while (((ec - m_rel) % 8) != 0) cyc();
      drive(1'b0);
      for (int i = 0; i < 5; i++) begin
         cyc();
         check("R9", cpu_rst_n, 1'b1);
      end
      drive(1'b1);
      for (int i = 0; i < 12; i++) begin
         cyc();
         check("R9", cpu_rst_n, 1'b1);
      end

      // R7/R8 sweep of offset and width of later reset pulses
      for (int d = 0; d < 8; d++) begin
         for (int w = 1; w <= 10; w++) begin
            drive(1'b1);
            for (int i = 0; i < 4 + d; i++) cyc();
            drive(1'b0);
            for (int i = 0; i < w; i++) cyc();
            drive(1'b1);
            for (int i = 0; i < 12; i++) cyc();
         end
      end

      // R3: power drop with system reset held inactive
      power_cycle(1'b1);
      pulse_seen = 0;
      for (int i = 0; i < 2; i++) begin
         cyc();
         check("R3", cpu_rst_n, 1'b0);
      end
      cyc();
      check("R3", cpu_rst_n, 1'b1);
      for (int i = 0; i < 10; i++) cyc();
      check("R6", (pulse_seen == 1), 1'b1);

      // Release at several phases after power good
      for (int r = 0; r < 10; r++) begin
         power_cycle(1'b0);
         for (int i = 0; i < r; i++) cyc();
         drive(1'b1);
         for (int i = 0; i < 12; i++) cyc();
         drive(1'b0);
         for (int i = 0; i < 2 + r; i++) cyc();
         drive(1'b1);
         for (int i = 0; i < 18; i++) cyc();
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule